// File: doc/BRIEF.md
# Byte Rotate and Shift Unit with Flag Generation

This block is a purely combinational 8-bit datapath element for a CPU's bit/rotate instruction group. An executor presents a 3-bit operation selector, the operand byte and the current carry flag. In the same cycle the block returns the rotated or shifted byte and a complete flag byte in the processor's flag layout. That flag byte includes the rarely documented copies of result bits 3 and 5 and a parity flag, so the block matches the processor bit for bit.

Eight operations are supported: four rotates (circular or through carry, in each direction), two left shifts and two right shifts. One of the left shifts is the undocumented form that forces a one into bit 0. The executor keeps operand selection, memory access and cycle counting.

Top module: `rot_shift_unit`

## Requirements
- R1: An even `op_i` (bit 0 clear) moves bits left, so result[7:1] = operand[6:0]. An odd `op_i` moves bits right, so result[6:0] = operand[7:1].
- R2: Circular rotates fill the vacated bit from the other end. For op 0, result[0] = operand[7]. For op 1, result[7] = operand[0].
- R3: Through-carry rotates fill the vacated bit with `carry_i`. This is result[0] for op 2 and result[7] for op 3.
- R4: Op 4 (arithmetic left) clears result[0]. Op 5 (arithmetic right) keeps result[7] = operand[7]. Op 7 (logical right) clears result[7].
- R5: Op 6 (left shift, set one) forces result[0] = 1.
- R6: Flag bit 0 (carry) equals operand[7] for the left operations and operand[0] for the right operations.
- R7: Flag bit 4 (half carry) and flag bit 1 (subtract) are 0 for every operation.
- R8: Flag bit 7 (sign) equals result[7]. Flag bit 6 (zero) is 1 exactly when the result is 0x00.
- R9: Flag bit 5 copies result[5] and flag bit 3 copies result[3].
- R10: Flag bit 2 (parity) is 1 when the result holds an even number of one bits, including zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| op_i | input | 3 | Operation selector: 0 circular left, 1 circular right, 2 left through carry, 3 right through carry, 4 arithmetic left, 5 arithmetic right, 6 left with one fill, 7 logical right |
| operand_i | input | 8 | Byte to rotate or shift |
| carry_i | input | 1 | Incoming carry flag |
| result_o | output | 8 | Rotated or shifted byte |
| flags_o | output | 8 | Flag byte: sign 7, zero 6, bit-5 copy 5, half 4, bit-3 copy 3, parity 2, subtract 1, carry 0 |

## Verification
The block has no registers, so both the result byte and the flag byte are due in the same cycle the inputs are applied, with zero cycles of latency. The bench changes inputs just after a rising edge and samples at the following falling edge. By then the outputs have settled, and the next stimulus has not yet arrived. Every combination of operation, operand and carry is covered, and each output field is compared with a value the bench computes arithmetically.

// File: rtl/rsu_pkg.sv
// Package: shared types and widths for the rotate/shift unit.
// Assumes a byte-wide datapath with the processor's fixed flag layout.
package rsu_pkg;
    localparam int unsigned DATA_W = 8;
    localparam int unsigned OP_W   = 3;
    localparam int unsigned MSB    = DATA_W - 1;

    // Flag bit positions within the flag byte
    localparam int unsigned FL_SIGN = 7;
    localparam int unsigned FL_ZERO = 6;
    localparam int unsigned FL_B5   = 5;
    localparam int unsigned FL_HALF = 4;
    localparam int unsigned FL_B3   = 3;
    localparam int unsigned FL_PAR  = 2;
    localparam int unsigned FL_SUB  = 1;
    localparam int unsigned FL_CARRY = 0;

    typedef enum logic [OP_W-1:0] {
        OP_ROT_L_CIRC  = 3'd0,
        OP_ROT_R_CIRC  = 3'd1,
        OP_ROT_L_CARRY = 3'd2,
        OP_ROT_R_CARRY = 3'd3,
        OP_SHL_ARITH   = 3'd4,
        OP_SHR_ARITH   = 3'd5,
        OP_SHL_ONE     = 3'd6,
        OP_SHR_LOGIC   = 3'd7
    } rsu_op_e;
endpackage

// File: rtl/rsu_fill_sel.sv
// Module: picks the bit entering the vacated end of the byte.
// Assumes the operation code has already been decoded into rsu_op_e.
module rsu_fill_sel
    import rsu_pkg::*;
(
    input  rsu_op_e           op,
    input  logic [DATA_W-1:0] opnd,
    input  logic              cin,
    output logic              fill
);
    // Choose the fill source for each operation
    always_comb begin
        unique case (op)
            OP_ROT_L_CIRC:  fill = opnd[MSB];
            OP_ROT_R_CIRC:  fill = opnd[0];
            OP_ROT_L_CARRY: fill = cin;
            OP_ROT_R_CARRY: fill = cin;
            OP_SHL_ARITH:   fill = 1'b0;
            OP_SHR_ARITH:   fill = opnd[MSB];
            OP_SHL_ONE:     fill = 1'b1;
            OP_SHR_LOGIC:   fill = 1'b0;
            default:        fill = 1'b0;
        endcase
    end
endmodule

// File: rtl/rsu_shift_core.sv
// Module: moves the operand one place and reports the bit pushed out.
// Assumes op[0] selects direction (0 left, 1 right), true for all codes.
module rsu_shift_core
    import rsu_pkg::*;
(
    input  rsu_op_e           op,
    input  logic [DATA_W-1:0] opnd,
    input  logic              cin,
    output logic [DATA_W-1:0] res,
    output logic              cout
);
    logic fill;

    rsu_fill_sel u_fill (
        .op   (op),
        .opnd (opnd),
        .cin  (cin),
        .fill (fill)
    );

    // Form the moved byte and the carried-out end bit
    always_comb begin
        if (op[0] == 1'b0) begin
            res  = {opnd[MSB-1:0], fill};
            cout = opnd[MSB];
        end else begin
            res  = {fill, opnd[MSB:1]};
            cout = opnd[0];
        end
    end
endmodule

// File: rtl/rsu_flag_gen.sv
// Module: builds the flag byte from the result and the carried-out bit.
// Assumes half carry and subtract are always cleared by this group.
module rsu_flag_gen
    import rsu_pkg::*;
(
    input  logic [DATA_W-1:0] res,
    input  logic              cout,
    output logic [DATA_W-1:0] flags
);
    logic even_ones;

    // Even parity: the XOR of all bits is zero
    always_comb even_ones = ~(^res);

    // Place each flag at its position
    always_comb begin
        flags           = '0;
        flags[FL_SIGN]  = res[MSB];
        flags[FL_ZERO]  = (res == '0);
        flags[FL_B5]    = res[5];
        flags[FL_HALF]  = 1'b0;
        flags[FL_B3]    = res[3];
        flags[FL_PAR]   = even_ones;
        flags[FL_SUB]   = 1'b0;
        flags[FL_CARRY] = cout;
    end
endmodule

// File: rtl/rot_shift_unit.sv
// Module: combinational byte rotate/shift unit with full flag output.
// Assumes the executor supplies the operand and carry and latches the outputs.
module rot_shift_unit
    import rsu_pkg::*;
(
    input  logic [2:0] op_i,
    input  logic [7:0] operand_i,
    input  logic       carry_i,
    output logic [7:0] result_o,
    output logic [7:0] flags_o
);
    rsu_op_e           op_dec;
    logic [DATA_W-1:0] res;
    logic              cout;

    // Decode the raw selector into the operation type
    always_comb op_dec = rsu_op_e'(op_i);

    rsu_shift_core u_core (
        .op   (op_dec),
        .opnd (operand_i),
        .cin  (carry_i),
        .res  (res),
        .cout (cout)
    );

    rsu_flag_gen u_flags (
        .res   (res),
        .cout  (cout),
        .flags (flags_o)
    );

    // Drive the result port
    always_comb result_o = res;
endmodule

// File: rtl/rot_shift_unit_chk.sv
// Checker: immediate assertions on the unit's ports; bound to rot_shift_unit.
// Assumes the ports settle together, since the unit holds no state.
module rot_shift_unit_chk (
    input logic [2:0] op_i,
    input logic [7:0] operand_i,
    input logic       carry_i,
    input logic [7:0] result_o,
    input logic [7:0] flags_o
);
    // Check every requirement against the current port values
    always_comb begin
        if (op_i[0] == 1'b0) begin
            p_left_move_r1: assert (result_o[7:1] == operand_i[6:0]);
            p_carry_left_r6: assert (flags_o[0] == operand_i[7]);
        end else begin
            p_right_move_r1: assert (result_o[6:0] == operand_i[7:1]);
            p_carry_right_r6: assert (flags_o[0] == operand_i[0]);
        end
        if (op_i == 3'd0) begin
            p_circ_left_r2: assert (result_o[0] == operand_i[7]);
        end
        if (op_i == 3'd1) begin
            p_circ_right_r2: assert (result_o[7] == operand_i[0]);
        end
        if (op_i == 3'd2) begin
            p_carry_in_left_r3: assert (result_o[0] == carry_i);
        end
        if (op_i == 3'd3) begin
            p_carry_in_right_r3: assert (result_o[7] == carry_i);
        end
        if (op_i == 3'd4) begin
            p_sla_zero_r4: assert (result_o[0] == 1'b0);
        end
        if (op_i == 3'd5) begin
            p_sra_sign_r4: assert (result_o[7] == operand_i[7]);
        end
        if (op_i == 3'd7) begin
            p_srl_zero_r4: assert (result_o[7] == 1'b0);
        end
        if (op_i == 3'd6) begin
            p_set_one_r5: assert (result_o[0] == 1'b1);
        end
        p_half_sub_clear_r7: assert (flags_o[4] == 1'b0 && flags_o[1] == 1'b0);
        p_sign_r8: assert (flags_o[7] == result_o[7]);
        p_zero_r8: assert (flags_o[6] == (result_o == 8'h00));
        p_copies_r9: assert (flags_o[5] == result_o[5] && flags_o[3] == result_o[3]);
        p_parity_r10: assert (flags_o[2] == ($countones(result_o) % 2 == 0));
    end
endmodule

bind rot_shift_unit rot_shift_unit_chk u_chk (
    .op_i      (op_i),
    .operand_i (operand_i),
    .carry_i   (carry_i),
    .result_o  (result_o),
    .flags_o   (flags_o)
);

// File: tb/rot_shift_unit_test.sv
// Bench: exhaustive sweep of operation, operand and carry for rot_shift_unit.
module rot_shift_unit_test;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [2:0] op_i = 3'd0;
    logic [7:0] operand_i = 8'd0;
    logic       carry_i = 1'b0;
    logic [7:0] result_o;
    logic [7:0] flags_o;

    int n_checks = 0;
    int n_errors = 0;
    bit finished = 1'b0;

    always #2 clk = ~clk;   // 250 MHz

    rot_shift_unit uut (
        .op_i      (op_i),
        .operand_i (operand_i),
        .carry_i   (carry_i),
        .result_o  (result_o),
        .flags_o   (flags_o)
    );

    task automatic chk(input string req, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_errors++;
            $display("FAIL %s op=%0d a=%02h c=%0d actual=%0h expected=%0h",
                     req, op_i, operand_i, carry_i, act, exp);
        end
    endtask

    function automatic int ones(input int v);
        int n = 0;
        for (int k = 0; k < 8; k++) n += (v >> k) & 1;
        return n;
    endfunction

    initial begin : watchdog
        #200000;
        if (!finished) begin
            n_checks++;
            n_errors++;
            $display("FAIL watchdog expired");
            $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
            $finish;
        end
    end

    initial begin : stim
        repeat (2) @(posedge clk);
        rst_n = 1'b1;
        // Quiet-input check: zero operand, op 0, no carry
        @(negedge clk);
        chk("R8 zero input result", int'(result_o), 0);
        chk("R10 zero input flags", int'(flags_o), 8'h44);
        for (int op = 0; op < 8; op++) begin
            for (int a = 0; a < 256; a++) begin
                for (int c = 0; c < 2; c++) begin
                    int left;
                    int fill;
                    int exp_res;
                    int exp_c;
                    int exp_f;
                    @(posedge clk);
                    op_i = 3'(op);
                    operand_i = 8'(a);
                    carry_i = c[0];
                    left = (op % 2 == 0) ? 1 : 0;
                    case (op)
                        0: fill = a / 128;
                        1: fill = a % 2;
                        2, 3: fill = c;
                        5: fill = a / 128;
                        6: fill = 1;
                        default: fill = 0;
                    endcase
                    if (left == 1) begin
                        exp_res = (a * 2) % 256 + fill;
                        exp_c = a / 128;
                    end else begin
                        exp_res = a / 2 + fill * 128;
                        exp_c = a % 2;
                    end
                    exp_f = ((exp_res >= 128) ? 128 : 0)
                          + ((exp_res == 0) ? 64 : 0)
                          + (((exp_res / 32) % 2) * 32)
                          + (((exp_res / 8) % 2) * 8)
                          + ((ones(exp_res) % 2 == 0) ? 4 : 0)
                          + exp_c;
                    @(negedge clk);
                    if (left == 1)
                        chk("R1 left move", int'(result_o) / 2, exp_res / 2);
                    else
                        chk("R1 right move", int'(result_o) % 128, exp_res % 128);
                    case (op)
                        0, 1: chk("R2 circular result", int'(result_o), exp_res);
                        2, 3: chk("R3 through-carry result", int'(result_o), exp_res);
                        6: chk("R5 set-one result", int'(result_o), exp_res);
                        default: chk("R4 shift result", int'(result_o), exp_res);
                    endcase
                    chk("R6 carry flag", int'(flags_o[0]), exp_c);
                    chk("R7 half/sub flags", int'({flags_o[4], flags_o[1]}), 0);
                    chk("R8 sign/zero flags", int'(flags_o[7:6]), exp_f / 64);
                    chk("R9 bit copies", int'({flags_o[5], flags_o[3]}),
                        ((exp_f / 32) % 2) * 2 + (exp_f / 8) % 2);
                    chk("R10 parity flag", int'(flags_o[2]), (exp_f / 4) % 2);
                end
            end
        end
        finished = 1'b1;
        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end
endmodule